// File: doc/BRIEF.md
# Predicated Delayed-Writeback Pipeline

This block is the back end of a wide-issue processor core with the arithmetic left out. Every clock it accepts one packet of several issue slots. Each valid slot carries the following fields:

- an operation class;
- a destination register;
- an optional predicate register with a polarity bit;
- a result value that is already computed.

A packet first crosses a fixed six-stage front section. Four of those stages stand for instruction fetch and two stand for dispatch and decode. The packet then reaches execute. From there each slot's result waits the number of delay slots that its class imposes, and then it is written to a 64-entry register file made of two sides of 32 registers.

The predicate is read from the register file in the last cycle before the write edge, not at issue. A predicate can therefore be produced by an instruction issued after the consumer, as long as that instruction lands earlier. When two committed writes land on the same register at the same edge, a sticky error flag is raised and a fixed priority picks the one value that is stored.

A combinational read port exposes the register file. It is the only way to observe results.

Top module: `pred_wb_pipe`

## Requirements
- R1: A synchronous active-high reset clears all 64 registers to zero and clears `err_collide`. It also discards every packet in flight, so no packet sampled before reset ever writes.
- R2: A slot sampled at clock edge n with class delay d is written at edge n+6+d. Before that edge `rd_data` still shows the old value, and from that edge on it shows the new one.
- R3: Class codes on `in_cls` map to delays as follows: code 0 → 0, code 1 → 1, code 2 → 2, code 3 → 4, code 4 → 5. Codes 5, 6 and 7 behave as code 0.
- R4: With `in_pen`=0 the write always commits. With `in_pen`=1 it commits only when (the predicate register is nonzero) XOR `in_pneg` is true.
- R5: The predicate value used is the register content in the cycle just before the write edge, including writes from all earlier edges. A predicate write landing on the same edge as the consumer is not seen.
- R6: Two complementary predicated writes to one register in one packet, `[p]` and `[!p]`, store exactly one value and do not raise `err_collide`.
- R7: Two committed writes to the same register at the same edge set `err_collide` from that edge on, and it stays set until reset. The stored value follows a fixed priority: the lower slot wins, and within one slot the lower class code wins.
- R8: Address bit 5 selects the side: 0 is side A, 1 is side B. Bits 4:0 select one of 32 registers in that side. The two sides are fully independent.
- R9: A slot whose `in_vld` bit is 0 writes nothing, whatever its other fields hold.
- R10: `rd_data` shows, combinationally, the register addressed by `rd_addr`.
- R11: Packets may arrive on consecutive cycles. Each of them writes at its own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | NSLOT (2) | Per-slot valid |
| in_cls | input | NSLOT×3 (6) | Per-slot class code |
| in_dst | input | NSLOT×6 (12) | Per-slot destination {side, index} |
| in_pen | input | NSLOT (2) | Per-slot predicate enable |
| in_pneg | input | NSLOT (2) | Per-slot predicate polarity (1 = write when register is zero) |
| in_preg | input | NSLOT×6 (12) | Per-slot predicate register {side, index} |
| in_val | input | NSLOT×32 (64) | Per-slot result value |
| rd_addr | input | 6 | Read port address {side, index} |
| rd_data | output | 32 | Read port data |
| err_collide | output | 1 | Sticky same-edge write collision flag |

## Verification
The assertions assume the following about the inputs:

- Reset is held from time zero.
- `rd_addr` can move freely; the hold check only applies while it is stable.
- Once no valid slot has been sampled for more than the front length plus the longest delay, nothing can change the register file.

The stimulus obeys these rules. Reset is raised before the first edge, and `rd_addr` is driven only at falling edges, so it stays stable across each rising edge. Predicate registers are either left untouched for long stretches or rewritten at exactly planned edges, so the sampling point under test is unambiguous.

// File: rtl/pred_wb_pipe.sv
module pred_wb_pipe #(
  parameter int NSLOT = 2,
  parameter int DW    = 32,
  parameter int RIW   = 5,
  parameter int FRONT = 6,
  localparam int AW   = RIW + 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NSLOT-1:0]               in_vld,
  input  logic [NSLOT-1:0][2:0]          in_cls,
  input  logic [NSLOT-1:0][AW-1:0]       in_dst,
  input  logic [NSLOT-1:0]               in_pen,
  input  logic [NSLOT-1:0]               in_pneg,
  input  logic [NSLOT-1:0][AW-1:0]       in_preg,
  input  logic [NSLOT-1:0][DW-1:0]       in_val,
  input  logic [AW-1:0]                  rd_addr,
  output logic [DW-1:0]                  rd_data,
  output logic                           err_collide
);

  localparam int NREG  = 2 ** AW;
  localparam int NCLS  = 5;
  localparam int NCAND = NSLOT * NCLS;
  localparam int MAXD  = 5;

  function automatic int cls_dly(input int c);
    case (c)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 4;
      default: return 5;
    endcase
  endfunction

  typedef struct packed {
    logic          v;
    logic [2:0]    cls;
    logic [AW-1:0] dst;
    logic          pe;
    logic          pn;
    logic [AW-1:0] pr;
    logic [DW-1:0] val;
  } pkt_t;

  typedef struct packed {
    logic          v;
    logic [AW-1:0] dst;
    logic          pe;
    logic          pn;
    logic [AW-1:0] pr;
    logic [DW-1:0] val;
  } lane_t;

  pkt_t          fr [FRONT][NSLOT];
  lane_t         cand [NCAND];
  logic [DW-1:0] rf [NREG];
  logic [NCAND-1:0] com;
  logic          coll;

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSLOT; s++) begin
      if (rst) begin
        for (int k = 0; k < FRONT; k++) fr[k][s] <= '0;
      end else begin
        fr[0][s] <= '{v: in_vld[s], cls: in_cls[s], dst: in_dst[s], pe: in_pen[s],
                      pn: in_pneg[s], pr: in_preg[s], val: in_val[s]};
        for (int k = 1; k < FRONT; k++) fr[k][s] <= fr[k-1][s];
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    pkt_t       ex;
    logic [2:0] ecls;
    assign ex   = fr[FRONT-1][s];
    assign ecls = (ex.cls > 3'd4) ? 3'd0 : ex.cls;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
      localparam int D = cls_dly(c);
      lane_t ent;
      assign ent = '{v: ex.v && (ecls == 3'(c)), dst: ex.dst, pe: ex.pe,
                     pn: ex.pn, pr: ex.pr, val: ex.val};
      if (D == 0) begin : g_direct
        assign cand[s*NCLS + c] = ent;
      end else begin : g_line
        lane_t ln [D];
        always_ff @(posedge clk) begin
          if (rst) begin
            for (int i = 0; i < D; i++) ln[i] <= '0;
          end else begin
            ln[D-1] <= ent;
            for (int i = 0; i < D-1; i++) ln[i] <= ln[i+1];
          end
        end
        assign cand[s*NCLS + c] = ln[0];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NCAND; k++)
      com[k] = cand[k].v && (!cand[k].pe || ((|rf[cand[k].pr]) ^ cand[k].pn));
    coll = 1'b0;
    for (int k = 1; k < NCAND; k++)
      for (int j = 0; j < k; j++)
        if (com[j] && com[k] && (cand[j].dst == cand[k].dst)) coll = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      for (int k = NCAND-1; k >= 0; k--)
        if (com[k]) rf[cand[k].dst] <= cand[k].val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       err_collide <= 1'b0;
    else if (coll) err_collide <= 1'b1;
  end

  assign rd_data = rf[rd_addr];

endmodule

// File: rtl/pred_wb_chk.sv
module pred_wb_chk #(
  parameter int NSLOT = 2,
  parameter int DW    = 32,
  parameter int AW    = 6,
  parameter int FRONT = 6,
  parameter int MAXD  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [NSLOT-1:0] in_vld,
  input logic [AW-1:0]    rd_addr,
  input logic [DW-1:0]    rd_data,
  input logic             err_collide
);

  logic [7:0] cnt;
  logic [7:0] idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      idle <= '0;
    end else begin
      if (cnt != 8'hFF) cnt <= cnt + 8'd1;
      if (|in_vld)            idle <= '0;
      else if (idle != 8'hFF) idle <= idle + 8'd1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cnt <= 8'(FRONT)) |-> (rd_data == '0)); // R1

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cnt <= 8'(FRONT)) |-> !err_collide); // R1

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_collide |=> err_collide); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((idle > 8'(FRONT + MAXD)) && $stable(rd_addr)) |-> $stable(rd_data)); // R9

endmodule

bind pred_wb_pipe pred_wb_chk #(
  .NSLOT(NSLOT), .DW(DW), .AW(AW), .FRONT(FRONT), .MAXD(MAXD)
) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .rd_addr(rd_addr),
  .rd_data(rd_data), .err_collide(err_collide)
);

// File: tb/pred_wb_pipe_test.sv
module pred_wb_pipe_test;

  localparam int A  = 0;
  localparam int B  = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      in_vld = '0;
  logic [1:0][2:0] in_cls = '0;
  logic [1:0][5:0] in_dst = '0;
  logic [1:0]      in_pen = '0;
  logic [1:0]      in_pneg = '0;
  logic [1:0][5:0] in_preg = '0;
  logic [1:0][31:0] in_val = '0;
  logic [5:0]      rd_addr = '0;
  logic [31:0]     rd_data;
  logic            err_collide;

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  bit ended = 0;

  typedef struct {
    int    due;
    int    addr;
    int    val;
    string tag;
  } item_t;

  item_t q[$];
  item_t it;

  pred_wb_pipe uut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_cls(in_cls), .in_dst(in_dst),
    .in_pen(in_pen), .in_pneg(in_pneg), .in_preg(in_preg), .in_val(in_val),
    .rd_addr(rd_addr), .rd_data(rd_data), .err_collide(err_collide)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int dly(input int c);
    case (c)
      1: return 1;
      2: return 2;
      3: return 4;
      4: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int due_of(input int c);
    return cyc + 7 + dly(c);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic chk_rd(input int addr, input int exp, input string tag);
    rd_addr = 6'(addr);
    #1;
    chk(tag, rd_data, 32'(exp));
  endtask

  task automatic expect_at(input int due, input int addr, input int val, input string tag);
    item_t n;
    int i;
    n.due = due; n.addr = addr; n.val = val; n.tag = tag;
    i = 0;
    while (i < q.size() && q[i].due <= due) i++;
    q.insert(i, n);
  endtask

  task automatic put(input int s, input int c, input int dst, input bit pe,
                     input bit pn, input int pr, input int val);
    in_vld[s]  = 1'b1;
    in_cls[s]  = 3'(c);
    in_dst[s]  = 6'(dst);
    in_pen[s]  = pe;
    in_pneg[s] = pn;
    in_preg[s] = 6'(pr);
    in_val[s]  = 32'(val);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    in_vld = '0;
  endtask

  task automatic drain();
    while (q.size() > 0) tick();
    tick();
    tick();
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      rd_addr = 6'(it.addr);
      #1;
      chk(it.tag, rd_data, 32'(it.val));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    int d1, d2;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    chk_rd(A+0, 0, "R1 reset A0");
    chk_rd(B+31, 0, "R1 reset B31");
    chk("R1 reset err", 32'(err_collide), 0);

    // R1: in-flight packet discarded by reset
    put(0, 0, A+3, 0, 0, 0, 'h55);
    tick(); tick();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    repeat (15) tick();
    chk_rd(A+3, 0, "R1 in-flight dropped");

    // R2 R3 R11: each class back to back, value appears at exact edge
    begin
      int codes[6] = '{0, 1, 2, 3, 4, 6};
      for (int i = 0; i < 6; i++) begin
        put(0, codes[i], A+10+i, 0, 0, 0, 'h100 + i);
        d1 = due_of(codes[i]);
        expect_at(d1 - 1, A+10+i, 0, "R2 before edge");
        expect_at(d1, A+10+i, 'h100 + i, "R3 class delay");
        tick();
      end
    end
    drain();

    // R4: predicate polarity
    put(0, 0, A+1, 0, 0, 0, 1);
    tick();
    drain();
    put(0, 0, B+0, 1, 0, A+1, 'hA0); d1 = due_of(0);
    put(1, 0, B+1, 1, 1, A+1, 'hA1);
    expect_at(d1, B+0, 'hA0, "R4 true pos");
    expect_at(d1, B+1, 0, "R4 neg of true");
    tick();
    put(0, 0, B+2, 1, 0, A+2, 'hA2); d1 = due_of(0);
    put(1, 0, B+3, 1, 1, A+2, 'hA3);
    expect_at(d1, B+2, 0, "R4 pos of zero");
    expect_at(d1, B+3, 'hA3, "R4 neg of zero");
    tick();
    drain();

    // R5: predicate sampled one cycle before the write edge
    put(0, 3, B+8, 1, 0, A+4, 'h1234); d1 = due_of(3);
    tick(); tick(); tick();
    put(0, 0, A+4, 0, 0, 0, 7);
    tick();
    expect_at(d1, B+8, 'h1234, "R5 late predicate seen");
    drain();
    put(0, 3, B+9, 1, 0, A+6, 'h5678); d2 = due_of(3);
    tick(); tick(); tick(); tick();
    put(0, 0, A+6, 0, 0, 0, 1);
    tick();
    expect_at(d2, B+9, 0, "R5 same-edge predicate unseen");
    expect_at(d2 + 3, B+9, 0, "R5 still unwritten");
    drain();

    // R6: complementary pair
    put(0, 0, A+20, 1, 0, A+1, 5); d1 = due_of(0);
    put(1, 0, A+20, 1, 1, A+1, 7);
    expect_at(d1, A+20, 5, "R6 pair p true");
    tick();
    put(0, 0, A+21, 1, 0, A+2, 5); d1 = due_of(0);
    put(1, 0, A+21, 1, 1, A+2, 7);
    expect_at(d1, A+21, 7, "R6 pair p false");
    tick();
    drain();
    chk("R6 no collision", 32'(err_collide), 0);

    // R8 sides, R9 invalid slot
    put(0, 0, A+5, 0, 0, 0, 'h111); d1 = due_of(0);
    put(1, 0, B+5, 0, 0, 0, 'h222);
    expect_at(d1, A+5, 'h111, "R8 side A");
    expect_at(d1, B+5, 'h222, "R8 side B");
    tick();
    put(0, 0, A+7, 0, 0, 0, 9); d1 = due_of(0);
    put(1, 0, A+22, 0, 0, 0, 'hDEAD);
    in_vld[1] = 1'b0;
    expect_at(d1, A+7, 9, "R9 valid neighbour");
    expect_at(d1 + 1, A+22, 0, "R9 invalid slot");
    tick();
    drain();
    chk("R8 no collision", 32'(err_collide), 0);

    // R7: collisions and priority
    put(0, 0, A+23, 0, 0, 0, 'hAA); d1 = due_of(0);
    put(1, 0, A+23, 0, 0, 0, 'hBB);
    expect_at(d1, A+23, 'hAA, "R7 lower slot wins");
    tick();
    drain();
    chk("R7 flag set", 32'(err_collide), 1);
    put(0, 3, A+24, 0, 0, 0, 'h11); d1 = due_of(3);
    tick(); tick(); tick(); tick();
    put(1, 0, A+24, 0, 0, 0, 'h22);
    tick();
    expect_at(d1, A+24, 'h11, "R7 cross-class slot priority");
    drain();
    put(0, 3, A+25, 0, 0, 0, 'h33); d1 = due_of(3);
    tick(); tick(); tick(); tick();
    put(0, 0, A+25, 0, 0, 0, 'h44);
    tick();
    expect_at(d1, A+25, 'h44, "R7 lower class code wins");
    drain();
    repeat (20) tick();
    chk("R7 flag sticky", 32'(err_collide), 1);
    chk_rd(A+5, 'h111, "R10 read port");
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 reset clears flag", 32'(err_collide), 0);
    chk_rd(A+25, 0, "R1 reset clears regs");
    finish_up();
  end

endmodule